// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the clock line for an I2C master from the system clock. It has two stages of division. A base prescaler divides the system clock by a power of two, and each tick it emits is one base tick. A phase controller then holds SCL low for a set number of base ticks and released for another set number. The low count and the high count are programmed separately. Both counts, together with the prescaler exponent, come from a packed 32-bit timing word.

A byte engine starts and stops the clock with a run control. While SCL is released, the block watches the sampled SCL line and counts high time only while the line actually reads high. A slave can therefore stretch the clock. Two one-cycle strobes tell the byte engine where it may change SDA (the middle of the low phase) and where it must sample SDA (the rising edge of SCL). The other timing fields in the upper bits of the word are captured together with the SCL counts and held on an output for neighbouring logic.

A parameter selects the count width. The full variant has 4-bit counts and the reduced variant has 3-bit counts.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted, and after it until run is raised, `scl_oe_o`, both strobes and `aux_timing_o` are 0.
- R2: Without stretching, every low phase (`scl_oe_o` = 1) lasts exactly (low+1) × 2^exp system clock cycles. Here exp is word bits 3:0 and low is the count field starting at bit 12.
- R3: Without stretching, every high phase (`scl_oe_o` = 0 between two low phases) lasts exactly (high+1) × 2^exp cycles. Here high is the count field starting at bit 16. The full SCL period is 2^exp × ((high+1)+(low+1)).
- R4: With the default count width of 4, exp comes from bits 3:0, low from bits 15:12 and high from bits 19:16. Bits 11:4 have no effect.
- R5: While SCL is released and `scl_in_i` reads 0, the high-phase count is frozen. The high phase ends after (high+1) × 2^exp cycles in which `scl_in_i` read 1.
- R6: `data_chg_stb_o` pulses for exactly one cycle per low phase, at cycle index floor(L/2) counted from 0 at the first low cycle, where L is the low-phase length.
- R7: `sample_stb_o` pulses for exactly one cycle per high phase, in the first released cycle in which `scl_in_i` reads 1.
- R8: When run is sampled low, `scl_oe_o` is 0 from the next cycle and all counters clear. When run is raised again, a complete low phase follows.
- R9: The timing word is captured on entry to each low phase. A change written during a period takes effect only at the next low phase.
- R10: `aux_timing_o` presents bits 31:20 of the captured word and stays constant from one capture to the next.
- R11: With a count width of 3, only bits 14:12 and 18:16 form the counts. Bits 15 and 19 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| timing_cfg_i | input | 32 | Packed timing word: exponent, low count, high count, held fields |
| run_i | input | 1 | 1 runs the clock; 0 releases SCL and clears the counters |
| scl_in_i | input | 1 | Sampled SCL line level |
| scl_oe_o | output | 1 | 1 drives SCL low; 0 releases it |
| data_chg_stb_o | output | 1 | One-cycle strobe in mid-low phase; SDA may change |
| sample_stb_o | output | 1 | One-cycle strobe at SCL rising edge; SDA is sampled |
| aux_timing_o | output | 12 | Captured bits 31:20 of the timing word |

## Verification
A prescaler count that is wrong shows up at the ports on the very first phase. The low length or high length then differs from the formula, and a bad exponent scales both lengths by a power of two. A phase counter that loads the wrong field, or compares against the wrong field, swaps or skews the two lengths within one period. It can also move the data-change strobe away from the half-way cycle. A stretch flag or a seen-high flag that is wrong shows up in the first stretched high phase, either as a high phase that is too short or as a missing or repeated sample strobe. A capture that comes too early shows up as a period whose length changes in the middle of a phase.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  localparam int CFG_W    = 32;
  localparam int EXP_LSB  = 0;
  localparam int LOW_LSB  = 12;
  localparam int HIGH_LSB = 16;
  localparam int AUX_LSB  = 20;
  localparam int AUX_W    = 12;

endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync_o = sync_q[1];

endmodule

// File: rtl/scl_base_prescaler.sv
module scl_base_prescaler #(
  parameter int EXP_W = 4,
  localparam int PRE_W = (1 << EXP_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             count_en_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o,
  output logic [PRE_W-1:0] cnt_o
);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;
  logic [PRE_W-1:0] limit;
  logic             cnt_we;

  // terminal count: 2^exp - 1
  always_comb begin
    limit = '0;
    for (int i = 0; i < PRE_W; i++) begin
      limit[i] = (i < int'(exp_i));
    end
  end

  assign tick_o = count_en_i && (cnt_q == limit);
  assign cnt_we = clear_i || count_en_i;

  always_comb begin
    if (clear_i) begin
      cnt_d = '0;
    end else if (tick_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R2
  pre_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_en_i |-> (cnt_q <= limit));

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_tg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             scl_in_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  output scl_phase_e       phase_o,
  output logic [CNT_W-1:0] ph_cnt_o,
  output logic             pre_clear_o,
  output logic             pre_en_o,
  output logic             load_cfg_o,
  output logic             sample_stb_o
);

  scl_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] ph_cnt_q, ph_cnt_d;
  logic             seen_q, seen_d;
  logic [CNT_W-1:0] field_sel;
  logic             phase_done;
  logic             phase_chg;
  logic             ph_cnt_we;

  assign field_sel  = (phase_q == PH_HIGH) ? high_cnt_i : low_cnt_i;
  assign phase_done = tick_i && (ph_cnt_q == field_sel);

  // next phase
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (run_i) phase_d = PH_LOW;
      PH_LOW: begin
        if (!run_i)          phase_d = PH_IDLE;
        else if (phase_done) phase_d = PH_HIGH;
      end
      PH_HIGH: begin
        if (!run_i)          phase_d = PH_IDLE;
        else if (phase_done) phase_d = PH_LOW;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign phase_chg = (phase_d != phase_q);

  // tick counter within a phase
  always_comb begin
    if (phase_chg || (phase_q == PH_IDLE)) begin
      ph_cnt_d = '0;
    end else begin
      ph_cnt_d = ph_cnt_q + CNT_W'(1);
    end
  end
  assign ph_cnt_we = phase_chg || (phase_q == PH_IDLE) || tick_i;

  // first high level seen in this high phase
  always_comb begin
    if ((phase_q == PH_HIGH) && (phase_d == PH_HIGH)) begin
      seen_d = seen_q | scl_in_i;
    end else begin
      seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_cnt_q <= '0;
    end else if (ph_cnt_we) begin
      ph_cnt_q <= ph_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
    end
  end

  assign phase_o      = phase_q;
  assign ph_cnt_o     = ph_cnt_q;
  assign pre_clear_o  = phase_chg || (phase_q == PH_IDLE);
  assign pre_en_o     = (phase_q == PH_LOW) || ((phase_q == PH_HIGH) && scl_in_i);
  assign load_cfg_o   = (phase_q != PH_LOW) && (phase_d == PH_LOW);
  assign sample_stb_o = (phase_q == PH_HIGH) && scl_in_i && !seen_q;

  // R2
  low_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) |-> (ph_cnt_q <= low_cnt_i));

  // R3
  high_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH) |-> (ph_cnt_q <= high_cnt_i));

  // R7
  sample_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb_o |=> !sample_stb_o);

endmodule

// File: rtl/scl_mid_strobe.sv
module scl_mid_strobe
  import scl_tg_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int EXP_W = 4,
  localparam int PRE_W = (1 << EXP_W) - 1,
  localparam int EL_W  = CNT_W + 1 + PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  scl_phase_e       phase_i,
  input  logic [CNT_W-1:0] ph_cnt_i,
  input  logic [PRE_W-1:0] pre_cnt_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  output logic             data_chg_stb_o
);

  logic [EL_W-1:0] elapsed;
  logic [EL_W-1:0] low_len;
  logic [EL_W-1:0] mid_point;

  // cycles elapsed in the low phase: prescaler count is below 2^exp
  assign elapsed   = (EL_W'(ph_cnt_i) << exp_i) | EL_W'(pre_cnt_i);
  assign low_len   = (EL_W'(low_cnt_i) + EL_W'(1)) << exp_i;
  assign mid_point = low_len >> 1;

  assign data_chg_stb_o = (phase_i == PH_LOW) && (elapsed == mid_point);

  // R6
  data_chg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_chg_stb_o |=> !data_chg_stb_o);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int EXP_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] timing_cfg_i,
  input  logic        run_i,
  input  logic        scl_in_i,
  output logic        scl_oe_o,
  output logic        data_chg_stb_o,
  output logic        sample_stb_o,
  output logic [11:0] aux_timing_o
);

  localparam int PRE_W = (1 << EXP_W) - 1;

  logic             rst_n_int;
  logic [EXP_W-1:0] exp_q;
  logic [CNT_W-1:0] low_q;
  logic [CNT_W-1:0] high_q;
  logic [AUX_W-1:0] aux_q;
  logic             load_cfg;
  logic             tick;
  logic [PRE_W-1:0] pre_cnt;
  logic             pre_clear;
  logic             pre_en;
  scl_phase_e       phase;
  logic [CNT_W-1:0] ph_cnt;
  logic             cfg_unused;

  assign cfg_unused = ^timing_cfg_i;

  scl_rst_sync u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  // timing word capture at each low-phase entry
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      exp_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
      aux_q  <= '0;
    end else if (load_cfg) begin
      exp_q  <= timing_cfg_i[EXP_LSB  +: EXP_W];
      low_q  <= timing_cfg_i[LOW_LSB  +: CNT_W];
      high_q <= timing_cfg_i[HIGH_LSB +: CNT_W];
      aux_q  <= timing_cfg_i[AUX_LSB  +: AUX_W];
    end
  end

  scl_base_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .clear_i    (pre_clear),
    .count_en_i (pre_en),
    .exp_i      (exp_q),
    .tick_o     (tick),
    .cnt_o      (pre_cnt)
  );

  scl_phase_ctrl #(.CNT_W(CNT_W)) u_phase (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .run_i        (run_i),
    .scl_in_i     (scl_in_i),
    .tick_i       (tick),
    .low_cnt_i    (low_q),
    .high_cnt_i   (high_q),
    .phase_o      (phase),
    .ph_cnt_o     (ph_cnt),
    .pre_clear_o  (pre_clear),
    .pre_en_o     (pre_en),
    .load_cfg_o   (load_cfg),
    .sample_stb_o (sample_stb_o)
  );

  scl_mid_strobe #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_mid (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .phase_i        (phase),
    .ph_cnt_i       (ph_cnt),
    .pre_cnt_i      (pre_cnt),
    .exp_i          (exp_q),
    .low_cnt_i      (low_q),
    .data_chg_stb_o (data_chg_stb_o)
  );

  assign scl_oe_o     = (phase == PH_LOW);
  assign aux_timing_o = aux_q;

  // R8
  run_low_release_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !run_i |=> !scl_oe_o);

  // R5
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((phase == PH_HIGH) && !scl_in_i && run_i) |=> $stable(pre_cnt));

  // R10
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (scl_oe_o && $past(scl_oe_o)) |-> $stable(aux_timing_o));

endmodule

// File: tb/sim_scl_timing_gen.sv
`timescale 1ns/1ps
module sim_scl_timing_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg, cfg1;
  logic        run, run1, stretch;
  logic        scl, scl1;
  logic        oe, dstb, sstb;
  logic        oe1, dstb1, sstb1;
  logic [11:0] aux, aux1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign scl  = ~oe & ~stretch;
  assign scl1 = ~oe1;

  scl_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .timing_cfg_i(cfg), .run_i(run), .scl_in_i(scl),
    .scl_oe_o(oe), .data_chg_stb_o(dstb), .sample_stb_o(sstb), .aux_timing_o(aux)
  );

  scl_timing_gen #(.CNT_W(3)) u1 (
    .clk(clk), .rst_n(rst_n), .timing_cfg_i(cfg1), .run_i(run1), .scl_in_i(scl1),
    .scl_oe_o(oe1), .data_chg_stb_o(dstb1), .sample_stb_o(sstb1), .aux_timing_o(aux1)
  );

  // exp, low, high, expected length cycles are derived below
  localparam int VEC [6][3] = '{
    '{0, 0, 0}, '{1, 3, 5}, '{2, 15, 0}, '{0, 7, 15}, '{3, 1, 2}, '{4, 0, 15}
  };

  function automatic logic [31:0] mk(int e, int l, int h, logic [11:0] a);
    logic [3:0] e4, l4, h4;
    e4 = e[3:0]; l4 = l[3:0]; h4 = h[3:0];
    return {a, h4, l4, 8'h00, e4};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // measures one full period after the current one
  task automatic measure(output int lo, output int hi, output int dpos,
                         output int dcnt, output int spos, output int scnt);
    lo = 0; hi = 0; dpos = -1; dcnt = 0; spos = -1; scnt = 0;
    while (oe) @(negedge clk);
    while (!oe) @(negedge clk);
    while (oe) begin
      if (dstb) begin dcnt++; if (dpos < 0) dpos = lo; end
      lo++;
      @(negedge clk);
    end
    while (!oe) begin
      if (sstb) begin scnt++; if (spos < 0) spos = hi; end
      hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lo, hi, dpos, dcnt, spos, scnt, el, eh, bad, aux_mid;
    rst_n = 1'b0; run = 1'b0; run1 = 1'b0; stretch = 1'b0;
    cfg = mk(2, 5, 5, 12'hFFF); cfg1 = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(oe == 1'b0, "R1", "oe in reset", int'(oe), 0);
    chk((dstb | sstb) == 1'b0, "R1", "strobes in reset", int'(dstb | sstb), 0);
    chk(aux == 12'h000, "R1", "aux in reset", int'(aux), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(oe == 1'b0, "R1", "oe idle after reset", int'(oe), 0);
    chk(aux == 12'h000, "R1", "aux idle after reset", int'(aux), 0);

    // R2 R3 R4 R6 R7 vector walk
    for (int v = 0; v < 6; v++) begin
      cfg = mk(VEC[v][0], VEC[v][1], VEC[v][2], 12'h000) | 32'h0000_0FF0;
      el = (VEC[v][1] + 1) << VEC[v][0];
      eh = (VEC[v][2] + 1) << VEC[v][0];
      run = 1'b1;
      measure(lo, hi, dpos, dcnt, spos, scnt);
      chk(lo == el, "R2", "low length", lo, el);
      chk(hi == eh, "R3", "high length", hi, eh);
      chk(dpos == el / 2 && dcnt == 1, "R6", "data strobe cycle", dpos, el / 2);
      chk(spos == 0 && scnt == 1, "R7", "sample strobe cycle", spos, 0);
      run = 1'b0;
      repeat (3) @(negedge clk);
    end

    // R5 clock stretching: exp 1, low 1, high 1 -> L 4, H 4
    cfg = mk(1, 1, 1, 12'h000);
    run = 1'b1;
    while (!oe) @(negedge clk);
    while (oe) @(negedge clk);
    stretch = 1'b1;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      #1;
      if (sstb || oe) bad++;
      @(negedge clk);
    end
    stretch = 1'b0;
    #1;
    hi = 0; spos = -1;
    while (!oe) begin
      if (sstb && spos < 0) spos = hi;
      hi++;
      @(negedge clk);
      #1;
    end
    chk(bad == 0, "R5", "no strobe or drive while stretched", bad, 0);
    chk(hi == 4, "R5", "high cycles after release", hi, 4);
    chk(spos == 0, "R7", "sample strobe at release", spos, 0);
    @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);

    // R8 stop mid-low and restart: exp 2, low 3 -> L 16
    cfg = mk(2, 3, 0, 12'h000);
    run = 1'b1;
    while (!oe) @(negedge clk);
    repeat (5) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk(oe == 1'b0, "R8", "release after stop", int'(oe), 0);
    bad = 0;
    repeat (4) begin @(negedge clk); if (oe || dstb || sstb) bad++; end
    chk(bad == 0, "R8", "quiet while stopped", bad, 0);
    run = 1'b1;
    @(negedge clk);
    lo = 0; dpos = -1;
    while (oe) begin
      if (dstb && dpos < 0) dpos = lo;
      lo++;
      @(negedge clk);
    end
    chk(lo == 16, "R8", "full low after restart", lo, 16);
    chk(dpos == 8, "R6", "data strobe after restart", dpos, 8);
    run = 1'b0;
    repeat (3) @(negedge clk);

    // R9 R10 mid-period change
    cfg = mk(1, 3, 1, 12'h5A5);
    run = 1'b1;
    while (!oe) @(negedge clk);
    while (oe) @(negedge clk);
    while (!oe) @(negedge clk);
    lo = 0; aux_mid = 0;
    while (oe) begin
      if (lo == 2) cfg = mk(0, 1, 1, 12'h3C3);
      if (lo == 4) aux_mid = int'(aux);
      lo++;
      @(negedge clk);
    end
    hi = 0;
    while (!oe) begin hi++; @(negedge clk); end
    chk(lo == 8, "R9", "low unchanged by mid write", lo, 8);
    chk(hi == 4, "R9", "high unchanged by mid write", hi, 4);
    chk(aux_mid == 12'h5A5, "R10", "aux held within period", aux_mid, 12'h5A5);
    lo = 0;
    while (oe) begin lo++; @(negedge clk); end
    hi = 0;
    while (!oe) begin hi++; @(negedge clk); end
    chk(lo == 2 && hi == 2, "R9", "new word next period", lo * 10 + hi, 22);
    chk(aux == 12'h3C3, "R10", "aux after capture", int'(aux), 12'h3C3);
    run = 1'b0;
    repeat (3) @(negedge clk);

    // R11 reduced count width: low field 4'hF -> 7, high 4'h9 -> 1
    cfg1 = mk(0, 15, 9, 12'h000);
    run1 = 1'b1;
    while (!oe1) @(negedge clk);
    while (oe1) @(negedge clk);
    while (!oe1) @(negedge clk);
    lo = 0;
    while (oe1) begin lo++; @(negedge clk); end
    hi = 0;
    while (!oe1) begin hi++; @(negedge clk); end
    chk(lo == 8, "R11", "reduced low length", lo, 8);
    chk(hi == 2, "R11", "reduced high length", hi, 2);
    run1 = 1'b0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule